// File: doc/BRIEF.md
# Split 64-bit Time Base Counter

This block keeps a 64-bit time base that counts up by one on each cycle where the clock source raises its enable. A processor sees the count as two 32-bit special-purpose registers, one for the high-order half and one for the low-order half. Reads and writes reach these registers through separate address numbers. Any privilege level may read. Only supervisor code may write, and an unprivileged write attempt is refused and reported on a fault output.

Reads return the live count with no snapshot or latch. Software reads the upper half, then the lower half, then the upper half again, and retries when the two upper values differ. The count wraps from all ones to zero silently. The block also watches a configurable number of tap bits, two by default, each chosen by a 6-bit index. For every tap it emits a one-cycle event when that bit goes from 0 to 1, whether the change came from counting or from a software write. Fixed-interval and watchdog timer logic downstream use these events.

Top module: `tbase_unit`

## Requirements
- R1: After synchronous reset both halves read as zero, and `priv_fault` and every `tap_evt` bit are low.
- R2: On each cycle with `inc_en` high and no accepted write, the 64-bit count increases by one, and a carry out of the lower half increments the upper half in the same cycle. With `inc_en` low and no accepted write, the count holds.
- R3: Reads and writes are decoded from different address sets: `RD_LO_ADDR`/`RD_HI_ADDR` for reads (default 0x0C0/0x0C1) and `WR_LO_ADDR`/`WR_HI_ADDR` for writes (default 0x0D0/0x0D1). A write to a read address changes nothing and raises no fault. A read of any address that is not a read address returns zero.
- R4: A write with `wr_priv` high to a write address replaces exactly that half with `wr_data` and leaves the other half unchanged.
- R5: An accepted write takes priority over the increment: in that cycle the written half takes `wr_data` and the other half holds, even with `inc_en` high.
- R6: A write to a write address with `wr_priv` low leaves the count unchanged, and `priv_fault` is high in the following cycle only.
- R7: Incrementing from all ones gives zero and raises no fault.
- R8: Tap k's 6-bit index in `tap_sel[6k+5:6k]` uses big-endian numbering: index 0 is the most significant bit of the upper half, index 31 its least significant bit, index 32 the most significant bit of the lower half, and index 63 its least significant bit. `tap_evt[k]` is high for one cycle, in the cycle the new count is first visible, exactly when the selected bit went from 0 to 1. A 1-to-0 change or a steady level gives no event.
- R9: A 0-to-1 change of a tapped bit caused by a privileged write produces the same event as one caused by counting.
- R10: `rd_data` reflects the current count combinationally on every read. A read of the upper half, then the lower half, then the upper half again shows a carry into the upper half that happened between the reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_en | input | 1 | Increment enable from the clock source |
| rd_addr | input | ADDR_W | Read register address |
| rd_data | output | 32 | Live read data for the addressed half, zero otherwise |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write register address |
| wr_data | input | 32 | Write data |
| wr_priv | input | 1 | High when the requester runs with supervisor privilege |
| priv_fault | output | 1 | One-cycle flag for a refused unprivileged write |
| tap_sel | input | 6*NUM_TAPS | Per-tap big-endian bit index |
| tap_evt | output | NUM_TAPS | Per-tap rising-edge event pulse |

## Verification
The bound checker watches on every cycle:
- the step and hold rules of the count;
- how a write splits between the two halves;
- the fault flag against refused attempts;
- read data against the live count, and zero for foreign addresses;
- each tap pulse against the selected bit's previous and new values.

The bench's scenarios are needed for three behaviours:
- the big-endian meaning of particular index values;
- the upper-lower-upper read sequence detecting a carry;
- the equality of write-caused and count-caused events at chosen bits.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int HALF_W = 32;
    localparam int FULL_W = 2 * HALF_W;
    localparam int SEL_W  = $clog2(FULL_W);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } tbase_t;

    typedef enum logic [1:0] {
        HALF_NONE = 2'd0,
        HALF_LO   = 2'd1,
        HALF_HI   = 2'd2
    } half_e;

    // Big-endian tap pick: index 0 is the top bit of the upper half.
    function automatic logic tap_bit(tbase_t v, logic [SEL_W-1:0] sel);
        logic [FULL_W-1:0] flat;
        flat = {v.hi, v.lo};
        return flat[~sel];
    endfunction

endpackage

// File: rtl/tbase_port.sv
module tbase_port
    import tbase_pkg::*;
#(
    parameter int                ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] RD_LO_ADDR = 10'h0C0,
    parameter logic [ADDR_W-1:0] RD_HI_ADDR = 10'h0C1,
    parameter logic [ADDR_W-1:0] WR_LO_ADDR = 10'h0D0,
    parameter logic [ADDR_W-1:0] WR_HI_ADDR = 10'h0D1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_priv,
    input  tbase_t            cnt,
    output logic [HALF_W-1:0] rd_data,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic              priv_fault
);

    half_e rd_half;
    half_e wr_half;
    logic  fault_q;

    always_comb begin
        if (rd_addr == RD_LO_ADDR)      rd_half = HALF_LO;
        else if (rd_addr == RD_HI_ADDR) rd_half = HALF_HI;
        else                            rd_half = HALF_NONE;
    end

    always_comb begin
        if (!wr_en)                     wr_half = HALF_NONE;
        else if (wr_addr == WR_LO_ADDR) wr_half = HALF_LO;
        else if (wr_addr == WR_HI_ADDR) wr_half = HALF_HI;
        else                            wr_half = HALF_NONE;
    end

    always_comb begin
        case (rd_half)
            HALF_LO: rd_data = cnt.lo;
            HALF_HI: rd_data = cnt.hi;
            default: rd_data = '0;
        endcase
    end

    assign wr_lo = (wr_half == HALF_LO) && wr_priv;
    assign wr_hi = (wr_half == HALF_HI) && wr_priv;

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= (wr_half != HALF_NONE) && !wr_priv;
    end

    assign priv_fault = fault_q;

endmodule

// File: rtl/tbase_count.sv
module tbase_count
    import tbase_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wr_data,
    output tbase_t            cnt_q,
    output tbase_t            cnt_d
);

    logic [HALF_W-1:0] lo_inc;
    logic [HALF_W-1:0] hi_inc;
    logic              lo_carry;

    always_comb begin
        {lo_carry, lo_inc} = {1'b0, cnt_q.lo} + {{HALF_W{1'b0}}, 1'b1};
        hi_inc = cnt_q.hi + {{(HALF_W-1){1'b0}}, lo_carry};
    end

    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_d.lo = wr_data;
            if (wr_hi) cnt_d.hi = wr_data;
        end else if (inc_en) begin
            cnt_d.lo = lo_inc;
            cnt_d.hi = hi_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/tbase_tap.sv
module tbase_tap
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  tbase_t           cur,
    input  tbase_t           nxt,
    output logic             evt
);

    logic rise;
    logic evt_q;

    // Same index on both sides, so a change of sel alone makes no event.
    assign rise = tap_bit(nxt, sel) && !tap_bit(cur, sel);

    always_ff @(posedge clk) begin
        if (rst) evt_q <= 1'b0;
        else     evt_q <= rise;
    end

    assign evt = evt_q;

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
    import tbase_pkg::*;
#(
    parameter int                ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] RD_LO_ADDR = 10'h0C0,
    parameter logic [ADDR_W-1:0] RD_HI_ADDR = 10'h0C1,
    parameter logic [ADDR_W-1:0] WR_LO_ADDR = 10'h0D0,
    parameter logic [ADDR_W-1:0] WR_HI_ADDR = 10'h0D1,
    parameter int                NUM_TAPS   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      inc_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [31:0]               rd_data,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [31:0]               wr_data,
    input  logic                      wr_priv,
    output logic                      priv_fault,
    input  logic [NUM_TAPS*6-1:0]     tap_sel,
    output logic [NUM_TAPS-1:0]       tap_evt
);

    tbase_t cnt_q;
    tbase_t cnt_d;
    logic   wr_lo;
    logic   wr_hi;

    tbase_port #(
        .ADDR_W    (ADDR_W),
        .RD_LO_ADDR(RD_LO_ADDR),
        .RD_HI_ADDR(RD_HI_ADDR),
        .WR_LO_ADDR(WR_LO_ADDR),
        .WR_HI_ADDR(WR_HI_ADDR)
    ) u_port (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (rd_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_priv   (wr_priv),
        .cnt       (cnt_q),
        .rd_data   (rd_data),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .priv_fault(priv_fault)
    );

    tbase_count u_count (
        .clk    (clk),
        .rst    (rst),
        .inc_en (inc_en),
        .wr_lo  (wr_lo),
        .wr_hi  (wr_hi),
        .wr_data(wr_data),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d)
    );

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        tbase_tap u_tap (
            .clk(clk),
            .rst(rst),
            .sel(tap_sel[k*SEL_W +: SEL_W]),
            .cur(cnt_q),
            .nxt(cnt_d),
            .evt(tap_evt[k])
        );
    end

endmodule

// File: rtl/tbase_unit_chk.sv
module tbase_unit_chk
    import tbase_pkg::*;
#(
    parameter int                ADDR_W     = 10,
    parameter logic [ADDR_W-1:0] RD_LO_ADDR = 10'h0C0,
    parameter logic [ADDR_W-1:0] RD_HI_ADDR = 10'h0C1,
    parameter logic [ADDR_W-1:0] WR_LO_ADDR = 10'h0D0,
    parameter logic [ADDR_W-1:0] WR_HI_ADDR = 10'h0D1,
    parameter int                NUM_TAPS   = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  inc_en,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [31:0]           rd_data,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [31:0]           wr_data,
    input logic                  wr_priv,
    input logic                  priv_fault,
    input logic [NUM_TAPS*6-1:0] tap_sel,
    input logic [NUM_TAPS-1:0]   tap_evt,
    input tbase_t                cnt
);

    logic [FULL_W-1:0] flat;
    logic              seen;
    logic              hit_lo;
    logic              hit_hi;
    logic              hit_any;
    logic              acc;
    logic              bad;
    tbase_t            prev_cnt;
    logic [NUM_TAPS*6-1:0] prev_sel;

    assign flat    = {cnt.hi, cnt.lo};
    assign hit_lo  = wr_en && (wr_addr == WR_LO_ADDR);
    assign hit_hi  = wr_en && (wr_addr == WR_HI_ADDR);
    assign hit_any = hit_lo || hit_hi;
    assign acc     = hit_any && wr_priv;
    assign bad     = hit_any && !wr_priv;

    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
        prev_cnt <= cnt;
        prev_sel <= tap_sel;
    end

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        inc_en && !acc |=> flat == $past(flat) + 64'd1);                   // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !inc_en && !acc |=> flat == $past(flat));                          // R2
    AST_WRAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (&flat) && inc_en && !wr_en |=> flat == '0 && !priv_fault);        // R7
    AST_WR_LO_ONLY: assert property (@(posedge clk) disable iff (rst)
        acc && hit_lo |=> cnt.lo == $past(wr_data) && cnt.hi == $past(cnt.hi)); // R5
    AST_WR_HI_ONLY: assert property (@(posedge clk) disable iff (rst)
        acc && hit_hi |=> cnt.hi == $past(wr_data) && cnt.lo == $past(cnt.lo)); // R4
    AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (rst)
        bad |=> priv_fault);                                               // R6
    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst || !seen)
        priv_fault |-> $past(bad));                                        // R6
    AST_BAD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        bad && !inc_en |=> flat == $past(flat));                           // R6
    AST_READ_LO_LIVE: assert property (@(posedge clk) disable iff (rst)
        rd_addr == RD_LO_ADDR |-> rd_data == cnt.lo);                      // R10
    AST_READ_HI_LIVE: assert property (@(posedge clk) disable iff (rst)
        rd_addr == RD_HI_ADDR |-> rd_data == cnt.hi);                      // R10
    AST_READ_FOREIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_addr != RD_LO_ADDR && rd_addr != RD_HI_ADDR |-> rd_data == '0); // R3

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_evt
        AST_EVT_EDGE: assert property (@(posedge clk) disable iff (rst || !seen)
            tap_evt[k] == (tap_bit(cnt, prev_sel[k*6 +: 6])
                           && !tap_bit(prev_cnt, prev_sel[k*6 +: 6])));    // R8
    end

endmodule

bind tbase_unit tbase_unit_chk #(
    .ADDR_W    (ADDR_W),
    .RD_LO_ADDR(RD_LO_ADDR),
    .RD_HI_ADDR(RD_HI_ADDR),
    .WR_LO_ADDR(WR_LO_ADDR),
    .WR_HI_ADDR(WR_HI_ADDR),
    .NUM_TAPS  (NUM_TAPS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .inc_en    (inc_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_priv   (wr_priv),
    .priv_fault(priv_fault),
    .tap_sel   (tap_sel),
    .tap_evt   (tap_evt),
    .cnt       (cnt_q)
);

// File: tb/tbase_unit_bench.sv
module tbase_unit_bench;

    localparam int        CLK_PERIOD = 10;
    localparam logic [9:0] A_RLO = 10'h0C0;
    localparam logic [9:0] A_RHI = 10'h0C1;
    localparam logic [9:0] A_WLO = 10'h0D0;
    localparam logic [9:0] A_WHI = 10'h0D1;

    typedef struct packed {
        logic [9:0]  addr;
        logic [31:0] data;
        logic        priv;
        logic [31:0] exp_lo;
        logic [31:0] exp_hi;
        logic        exp_fault;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{A_WLO, 32'h12345678, 1'b1, 32'h12345678, 32'h00000000, 1'b0}, // R4
        '{A_WHI, 32'hCAFEF00D, 1'b1, 32'h12345678, 32'hCAFEF00D, 1'b0}, // R4
        '{A_WLO, 32'hDEADBEEF, 1'b0, 32'h12345678, 32'hCAFEF00D, 1'b1}, // R6
        '{A_RLO, 32'h00000001, 1'b1, 32'h12345678, 32'hCAFEF00D, 1'b0}, // R3
        '{A_RHI, 32'h00000002, 1'b0, 32'h12345678, 32'hCAFEF00D, 1'b0}, // R3
        '{A_WHI, 32'h00000000, 1'b1, 32'h12345678, 32'h00000000, 1'b0}, // R4
        '{A_WHI, 32'hFFFFFFFF, 1'b0, 32'h12345678, 32'h00000000, 1'b1}  // R6
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inc_en = 1'b0;
    logic [9:0]  rd_addr = A_RLO;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_priv = 1'b0;
    logic        priv_fault;
    logic [11:0] tap_sel = '0;
    logic [1:0]  tap_evt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbase_unit #(
        .ADDR_W(10), .RD_LO_ADDR(A_RLO), .RD_HI_ADDR(A_RHI),
        .WR_LO_ADDR(A_WLO), .WR_HI_ADDR(A_WHI), .NUM_TAPS(2)
    ) u_tbase_unit (
        .clk(clk), .rst(rst), .inc_en(inc_en),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_priv(wr_priv),
        .priv_fault(priv_fault), .tap_sel(tap_sel), .tap_evt(tap_evt)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // Drive at a falling edge, hold over one rising edge, return at the next falling edge.
    task automatic wr(logic [9:0] a, logic [31:0] d, logic p);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_priv = p;
        @(negedge clk);
        wr_en = 1'b0; wr_priv = 1'b0;
    endtask

    task automatic step();
        inc_en = 1'b1;
        @(negedge clk);
        inc_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] h1;
        logic [31:0] h2;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_RLO, v); check("R1 lo", v, 32'h0);
        rd(A_RHI, v); check("R1 hi", v, 32'h0);
        check("R1 fault", {31'b0, priv_fault}, 32'h0);
        check("R1 evt", {30'b0, tap_evt}, 32'h0);

        // Table: writes, refused writes, writes to read addresses
        for (int i = 0; i < NVEC; i++) begin
            wr(VECS[i].addr, VECS[i].data, VECS[i].priv);
            check("R4/R6/R3 fault", {31'b0, priv_fault}, {31'b0, VECS[i].exp_fault});
            rd(A_RLO, v); check("R4/R6/R3 lo", v, VECS[i].exp_lo);
            rd(A_RHI, v); check("R4/R6/R3 hi", v, VECS[i].exp_hi);
        end
        @(negedge clk);
        check("R6 fault one cycle", {31'b0, priv_fault}, 32'h0);

        // R3 read of a write address returns zero
        rd(A_WLO, v); check("R3 foreign read", v, 32'h0);

        // R2 increment and carry
        wr(A_WLO, 32'hFFFFFFFE, 1'b1);
        wr(A_WHI, 32'h00000005, 1'b1);
        step();
        rd(A_RLO, v); check("R2 lo step", v, 32'hFFFFFFFF);
        rd(A_RHI, h1); check("R2 hi before carry", h1, 32'h5);
        step();
        rd(A_RLO, v); check("R2 carry lo", v, 32'h0);
        rd(A_RHI, h2); check("R10 reread hi", h2, 32'h6);
        check("R10 mismatch seen", {31'b0, h1 != h2}, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_RLO, v); check("R2 hold lo", v, 32'h0);
        rd(A_RHI, v); check("R2 hold hi", v, 32'h6);

        // R7 wrap
        wr(A_WLO, 32'hFFFFFFFF, 1'b1);
        wr(A_WHI, 32'hFFFFFFFF, 1'b1);
        step();
        rd(A_RLO, v); check("R7 wrap lo", v, 32'h0);
        rd(A_RHI, v); check("R7 wrap hi", v, 32'h0);
        check("R7 no fault", {31'b0, priv_fault}, 32'h0);

        // R5 write beats increment
        inc_en = 1'b1;
        wr(A_WLO, 32'd100, 1'b1);
        inc_en = 1'b0;
        rd(A_RLO, v); check("R5 lo written", v, 32'd100);
        rd(A_RHI, v); check("R5 hi held", v, 32'h0);

        // R8 tap 0 on index 63 (lower LSB), tap 1 on index 31 (upper LSB)
        tap_sel = {6'd31, 6'd63};
        @(negedge clk);
        step();
        check("R8 rise by count", {31'b0, tap_evt[0]}, 32'h1);
        @(negedge clk);
        check("R8 single pulse", {31'b0, tap_evt[0]}, 32'h0);
        step();
        check("R8 no evt on fall", {31'b0, tap_evt[0]}, 32'h0);

        // R9 write-caused rise on index 31
        wr(A_WHI, 32'h00000001, 1'b1);
        check("R9 rise by write", {31'b0, tap_evt[1]}, 32'h1);
        check("R9 other tap quiet", {31'b0, tap_evt[0]}, 32'h0);
        @(negedge clk);
        check("R9 level no evt", {31'b0, tap_evt[1]}, 32'h0);

        // R8 index 0 is the upper half's MSB
        tap_sel[11:6] = 6'd0;
        @(negedge clk);
        wr(A_WHI, 32'h80000000, 1'b1);
        check("R8 msb index 0", {31'b0, tap_evt[1]}, 32'h1);
        wr(A_WHI, 32'h40000000, 1'b0);
        check("R9 refused write no evt", {31'b0, tap_evt[1]}, 32'h0);

        // R8 carry into index 31
        tap_sel[11:6] = 6'd31;
        wr(A_WLO, 32'hFFFFFFFF, 1'b1);
        step();
        check("R8 carry rise", {31'b0, tap_evt[1]}, 32'h1);
        rd(A_RHI, v); check("R2 carry hi", v, 32'h80000001);

        finish_run();
    end

endmodule